// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one column address into the column address of every beat of a memory burst. A single-cycle start pulse captures the starting column, a three-bit burst-length code and a burst-order select. From the next cycle onward, the block presents one column per clock until the burst is complete.

Two orders are supported. In sequential order, the low offset counts up from the starting position and wraps inside an aligned block of 4 or 8 columns. In interleaved order, the offset is the starting position XORed with the beat index. In both orders, the column bits above the block stay fixed for the whole burst.

The block flags two kinds of bad request: a length code it does not support, and a start that arrives while a burst is still running.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, valid_o, last_o, len_err_o and busy_err_o are all low.
- R2: A start with len_code_i = 3'b010 produces 4 beats and one with 3'b011 produces 8 beats. valid_o is high on consecutive cycles, starting in the cycle after the start edge.
- R3: With order_i = 0 (sequential), beat k carries the low offset (s + k) mod L, where L is 4 (bits 1:0) or 8 (bits 2:0) and s is the starting offset held in those bits.
- R4: With order_i = 1 (interleaved), beat k carries the low offset s XOR k over the same 2 or 3 bits.
- R5: Every column bit above the low 2 bits (length 4) or the low 3 bits (length 8) equals the starting column on every beat.
- R6: last_o is high on the final beat only, and never while valid_o is low.
- R7: A start with any other length code starts no burst, and len_err_o is high for exactly the following cycle.
- R8: A start in any cycle where valid_o is high, including the last beat, is ignored. The running burst continues unchanged, and busy_err_o is high for exactly the following cycle.
- R9: Length, order and column are captured at the accepted start. Changes to these inputs during the burst have no effect.
- R10: Once the final beat has completed, the next start is accepted as a new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst request pulse |
| col_i | input | COL_W | Starting column |
| len_code_i | input | 3 | Burst length code (010 = 4, 011 = 8) |
| order_i | input | 1 | 0 = sequential, 1 = interleaved |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | Beat present |
| last_o | output | 1 | Final beat of the burst |
| len_err_o | output | 1 | Pulse: unsupported length code |
| busy_err_o | output | 1 | Pulse: start ignored while busy |

## Verification
The hardest case to reach is a start that lands exactly on the last beat. It must still be ignored, even though the burst ends at that same edge, and the next start must then be accepted normally. The stimulus reaches this case by injecting a second start at a chosen beat index of a running burst: sometimes the final beat, sometimes a middle one. Random starting columns and random changes to the inputs during the burst cover every offset and wrap point, in both orders.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int OFF_W = 3;
  localparam logic [2:0] LEN_CODE_4 = 3'b010;
  localparam logic [2:0] LEN_CODE_8 = 3'b011;

  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} order_e;

  typedef struct packed {
    logic   len8;
    order_e order;
  } burst_cfg_t;
endpackage

// File: rtl/len_decode.sv
module len_decode
  import burst_seq_pkg::*;
(
  input  logic [2:0] code_i,
  output logic       ok_o,
  output logic       len8_o
);
  always_comb begin
    ok_o   = 1'b0;
    len8_o = 1'b0;
    unique case (code_i)
      LEN_CODE_4: ok_o = 1'b1;
      LEN_CODE_8: begin ok_o = 1'b1; len8_o = 1'b1; end
      default:    ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/beat_ctrl.sv
module beat_ctrl
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             code_ok_i,
  input  logic             len8_i,
  input  logic             order_i,
  input  logic [COL_W-1:0] col_i,
  output logic             active_o,
  output logic             last_o,
  output logic [OFF_W-1:0] beat_o,
  output logic [COL_W-1:0] base_o,
  output burst_cfg_t       cfg_o,
  output logic             len_err_o,
  output logic             busy_err_o
);
  logic accept;
  logic [OFF_W-1:0] final_beat;

  assign final_beat = cfg_o.len8 ? 3'd7 : 3'd3;
  assign last_o     = active_o && (beat_o == final_beat);
  assign accept     = start_i && !active_o && code_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o   <= 1'b0;
      beat_o     <= '0;
      base_o     <= '0;
      cfg_o      <= '{len8: 1'b0, order: ORD_SEQ};
      len_err_o  <= 1'b0;
      busy_err_o <= 1'b0;
    end else begin
      len_err_o  <= start_i && !active_o && !code_ok_i;
      busy_err_o <= start_i && active_o;
      if (accept) begin
        active_o <= 1'b1;
        beat_o   <= '0;
        base_o   <= col_i;
        cfg_o    <= '{len8: len8_i, order: order_e'(order_i)};
      end else if (last_o) begin
        active_o <= 1'b0;
        beat_o   <= '0;
      end else if (active_o) begin
        beat_o <= beat_o + 3'd1;
      end
    end
  end

  // R6: final beat ends the burst
  a_r6_last_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !active_o);
  // R2: no gap inside a burst
  a_r2_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && !last_o |=> active_o);
  // R8: start while busy flagged and burst config held
  a_r8_busy_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && active_o |=> busy_err_o);
  a_r9_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && !last_o |=> $stable(cfg_o) && $stable(base_o));
  // R7: bad code starts nothing
  a_r7_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_err_o |-> !active_o);
endmodule

// File: rtl/col_map.sv
module col_map
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [OFF_W-1:0] beat_i,
  input  burst_cfg_t       cfg_i,
  output logic [COL_W-1:0] col_o
);
  logic [OFF_W-1:0] mask, start_off, off, low;

  assign mask      = cfg_i.len8 ? 3'b111 : 3'b011;
  assign start_off = base_i[OFF_W-1:0] & mask;

  always_comb begin
    if (cfg_i.order == ORD_ILV) off = start_off ^ beat_i;
    else                        off = start_off + beat_i;
    low = (base_i[OFF_W-1:0] & ~mask) | (off & mask);
  end

  assign col_o = {base_i[COL_W-1:OFF_W], low};
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       len_code_i,
  input  logic             order_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             len_err_o,
  output logic             busy_err_o
);
  logic             code_ok, len8;
  logic [OFF_W-1:0] beat;
  logic [COL_W-1:0] base;
  burst_cfg_t       cfg;

  len_decode u_dec (.code_i(len_code_i), .ok_o(code_ok), .len8_o(len8));

  beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .code_ok_i(code_ok), .len8_i(len8), .order_i, .col_i,
    .active_o(valid_o), .last_o, .beat_o(beat), .base_o(base), .cfg_o(cfg),
    .len_err_o, .busy_err_o
  );

  col_map #(.COL_W(COL_W)) u_map (
    .base_i(base), .beat_i(beat), .cfg_i(cfg), .col_o
  );

  // R5: column bits above the largest block never move within a burst
  a_r5_upper_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !last_o |=> $stable(col_o[COL_W-1:OFF_W]));
  // R6: last only with a beat
  a_r6_last_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
  // R7/R8: the two error pulses never coincide
  a_r7_r8_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(len_err_o && busy_err_o));
endmodule

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
  localparam int COL_W = 10;

  logic             clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, order_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic [2:0]       len_code_i = '0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o, len_err_o, busy_err_o;

  int n_run = 0, n_fail = 0, cycles = 0;

  burst_col_seq #(.COL_W(COL_W)) dut (.*);

  always #10 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles == 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] c, bit l8,
                                               bit ilv, int k);
    int msk = l8 ? 7 : 3;
    int s = c & msk;
    int off = ilv ? (s ^ k) : ((s + k) % (msk + 1));
    return (c & ~COL_W'(msk)) | COL_W'(off);
  endfunction

  // inj: beat index at which a second start is driven, -1 for none
  task automatic burst(logic [COL_W-1:0] c, bit l8, bit ilv, int inj);
    int n = l8 ? 8 : 4;
    @(negedge clk_i);
    start_i = 1'b1; col_i = c; len_code_i = l8 ? 3'b011 : 3'b010; order_i = ilv;
    @(negedge clk_i);
    start_i = 1'b0;
    col_i = COL_W'($urandom); len_code_i = 3'($urandom); order_i = 1'($urandom); // R9
    for (int k = 0; k < n; k++) begin
      chk("R2 valid", valid_o, 1);
      chk(ilv ? "R4 col" : "R3 col", col_o, exp_col(c, l8, ilv, k));
      chk("R5 upper", col_o >> (l8 ? 3 : 2), c >> (l8 ? 3 : 2));
      chk("R6 last", last_o, k == n - 1);
      if (k > 0 && k - 1 == inj) chk("R8 busy_err", busy_err_o, 1);
      if (k == inj) begin
        start_i = 1'b1; col_i = COL_W'($urandom); len_code_i = 3'b011;
      end
      @(negedge clk_i);
      start_i = 1'b0;
    end
    chk("R2 end", valid_o, 0);
    if (inj == n - 1) chk("R8 busy_err on last", busy_err_o, 1);
    else chk("R8 no busy_err", busy_err_o, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk_i);
    chk("R1 valid", valid_o, 0);
    chk("R1 last", last_o, 0);
    chk("R1 errs", {len_err_o, busy_err_o}, 0);
    rst_ni = 1'b1;
    // directed corners
    burst(10'h3fe, 1'b0, 1'b0, -1);
    burst(10'h125, 1'b1, 1'b0, -1);
    burst(10'h0a6, 1'b1, 1'b1, -1);
    burst(10'h003, 1'b0, 1'b1, -1);
    burst(10'h2f7, 1'b1, 1'b0, 7);   // R8 on last beat
    burst(10'h011, 1'b0, 1'b1, 1);   // R10 follows immediately
    // unsupported codes (R7)
    for (int c = 0; c < 8; c++) begin
      if (c == 2 || c == 3) continue;
      @(negedge clk_i);
      start_i = 1'b1; len_code_i = 3'(c); col_i = COL_W'($urandom);
      @(negedge clk_i);
      start_i = 1'b0;
      chk("R7 len_err", len_err_o, 1);
      chk("R7 no burst", valid_o, 0);
      @(negedge clk_i);
      chk("R7 pulse width", len_err_o, 0);
    end
    // random mix
    for (int i = 0; i < 300; i++) begin
      bit l8 = 1'($urandom);
      int inj = ($urandom % 3 == 0) ? int'($urandom % (l8 ? 8 : 4)) : -1;
      burst(COL_W'($urandom), l8, 1'($urandom), inj);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule